// File: doc/BRIEF.md
# Sync Polarity Corrector and Display Mode Decoder

This block receives the horizontal and vertical sync lines of a display timing source as already-sliced digital levels. It works out the active polarity of each line by integrating it over time: a valid sync pulse is active for no more than 30% of its period, so the level that dominates must be the inactive one. Each line gets a saturating up/down counter that advances on a slow prescaler tick. Two hysteresis thresholds turn the counter value into a polarity bit, so the bit flips only after a sustained reversal of the duty cycle.

The detected polarities have two uses. First, they normalise both sync lines into active-high copies. Second, they select one of three fixed display modes or a fourth mode whose timing is set outside the block. The block reports the mode as a code, raises a flag for the fourth mode, and outputs a vertical amplitude preset in tenths of a percent relative to the 60 Hz / 480-line mode. A multi-frequency override input forces the preset to the neutral 100% value. The decoded mode code and the fourth-mode flag are not affected by the override.

The timing constants are parameters. With a real clock, `TICK_DIV` and the thresholds are chosen so that a horizontal polarity change reaches the outputs between 0.3 ms and 1.8 ms after it happens. The same choice means vertical pulses up to 300 µs wide never move the vertical counter far from its rail.

Top module: `sync_pol_mode`

## Requirements
- R1: While `rst_ni` is low and after its release, both polarities read positive, both counters are 0, `mode_o` is 3, `mode4_o` is 1, `preset_o` is 1000, and `hsync_o` and `vsync_o` are 0.
- R2: Each line's counter changes only on a prescaler tick, which comes once every `TICK_DIV` clocks. On a tick it goes up by one if the line is high and down by one if it is low. It saturates at 0 and at `CNT_MAX`.
- R3: A line's polarity becomes negative once its counter is at least `HI_TH`, and positive once its counter is at most `LO_TH`. Otherwise it holds. A reversal too short to reach the opposite threshold leaves the polarity and `mode_o` unchanged.
- R4: From a saturated counter, a constant opposite level changes `mode_o` between (T-1)*`TICK_DIV`+3 and T*`TICK_DIV`+2 clocks after the level changes. T is `HI_TH` when rising from 0 and `CNT_MAX`-`LO_TH` when falling from `CNT_MAX`.
- R5: `hsync_o` and `vsync_o` equal their raw input XOR the line's negative-polarity bit, registered once. Each is therefore high during the active phase of its sync, whatever that sync's polarity.
- R6: `mode_o`, registered from the polarities (horizontal/vertical), is 0 for positive/negative, 1 for negative/positive, 2 for negative/negative and 3 for positive/positive.
- R7: `mode4_o` is 1 exactly when `mode_o` is 3, and 0 for codes 0 to 2.
- R8: With the override low, `preset_o` is 1168 for mode code 0, 1022 for code 1, and 1000 for codes 2 and 3.
- R9: With `multi_freq_i` high, `preset_o` is 1000 one clock later, whatever the mode, and `mode_o` and `mode4_o` still follow the decode.
- R10: A vertical input tied low keeps the vertical polarity positive indefinitely. `vsync_o` then stays 0, and the mode follows the horizontal polarity alone (code 1 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Raw horizontal sync level, any polarity |
| vsync_i | input | 1 | Raw vertical sync level, any polarity, tie low if unused |
| multi_freq_i | input | 1 | Forces the neutral amplitude preset when high |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| mode_o | output | 2 | Decoded display mode code 0..3 |
| mode4_o | output | 1 | High for the externally defined fourth mode |
| preset_o | output | 11 | Vertical amplitude preset in 0.1% units |

## Verification
The bench drives random sync trains with random periods and active widths up to 30%, in all four polarity pairs and in random order. Steady-state corrected sync, mode code, flag and preset are compared with values computed from the requirement tables, which separates a wrong decode from a wrong polarity decision. Constant levels held from a saturated counter measure the flip latency window, and a held-high phase well past `CNT_MAX` shows that the counter saturates, because overflow would lengthen the return flip. A reversal held just short of the threshold must leave the mode untouched, and a vertical line tied low must settle to a positive vertical polarity.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int PRESET_W = 11;

  typedef enum logic [1:0] {
    MODE_350 = 2'd0,
    MODE_400 = 2'd1,
    MODE_480 = 2'd2,
    MODE_EXT = 2'd3
  } mode_e;

  localparam logic [PRESET_W-1:0] PRESET_UNITY = PRESET_W'(1000);
  localparam logic [PRESET_W-1:0] PRESET_350   = PRESET_W'(1168);
  localparam logic [PRESET_W-1:0] PRESET_400   = PRESET_W'(1022);

  localparam int CH_H = 0;
  localparam int CH_V = 1;
  localparam int N_CH = 2;
endpackage

// File: rtl/spm_tick.sv
module spm_tick #(
  parameter int TICK_DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          div_q <= '0;
        else if (div_q == DW'(TICK_DIV - 1))  div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/spm_pol_integ.sv
module spm_pol_integ #(
  parameter int CNT_MAX = 255,
  parameter int HI_TH   = 192,
  parameter int LO_TH   = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sync_i,
  output logic pol_neg_o,
  output logic sync_o
);
  localparam int CW = $clog2(CNT_MAX + 1);

  logic [CW-1:0] acc_q;
  logic          pol_q;
  logic          sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (tick_i) begin
      if (sync_i && acc_q != CW'(CNT_MAX)) acc_q <= acc_q + 1'b1;
      else if (!sync_i && acc_q != '0)     acc_q <= acc_q - 1'b1;
    end
  end

  // hysteresis: hold between thresholds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pol_q <= 1'b0;
    else if (acc_q >= CW'(HI_TH))    pol_q <= 1'b1;
    else if (acc_q <= CW'(LO_TH))    pol_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i ^ pol_q;
  end

  assign pol_neg_o = pol_q;
  assign sync_o    = sync_q;

  assert_acc_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= CW'(CNT_MAX));
  assert_acc_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q != $past(acc_q)) |-> $past(tick_i));
  assert_neg_needs_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pol_q) |-> $past(acc_q) >= CW'(HI_TH));
  assert_pos_needs_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pol_q) |-> $past(acc_q) <= CW'(LO_TH));
endmodule

// File: rtl/spm_mode_dec.sv
module spm_mode_dec
  import spm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CH-1:0]     pol_neg_i,
  input  logic                multi_freq_i,
  output mode_e               mode_o,
  output logic                mode4_o,
  output logic [PRESET_W-1:0] preset_o
);
  mode_e               mode_d, mode_q;
  logic [PRESET_W-1:0] preset_d, preset_q;
  logic                mode4_q;

  always_comb begin
    unique case ({pol_neg_i[CH_H], pol_neg_i[CH_V]})
      2'b01:   mode_d = MODE_350;
      2'b10:   mode_d = MODE_400;
      2'b11:   mode_d = MODE_480;
      default: mode_d = MODE_EXT;
    endcase
    if (multi_freq_i)            preset_d = PRESET_UNITY;
    else if (mode_d == MODE_350) preset_d = PRESET_350;
    else if (mode_d == MODE_400) preset_d = PRESET_400;
    else                         preset_d = PRESET_UNITY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_EXT;
      mode4_q  <= 1'b1;
      preset_q <= PRESET_UNITY;
    end else begin
      mode_q   <= mode_d;
      mode4_q  <= ({pol_neg_i[CH_H], pol_neg_i[CH_V]} == 2'b00);
      preset_q <= preset_d;
    end
  end

  assign mode_o   = mode_q;
  assign mode4_o  = mode4_q;
  assign preset_o = preset_q;

  assert_flag_matches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode4_q == (mode_q == MODE_EXT));
  assert_override_unity_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_freq_i |=> preset_q == PRESET_UNITY);
  assert_mode_follows_pol_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> ($past(pol_neg_i) != $past(pol_neg_i, 2)));
  assert_boost_only_350_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_q == PRESET_350) |-> (mode_q == MODE_350));
endmodule

// File: rtl/sync_pol_mode.sv
module sync_pol_mode
  import spm_pkg::*;
#(
  parameter int TICK_DIV = 64,
  parameter int CNT_MAX  = 255,
  parameter int HI_TH    = 192,
  parameter int LO_TH    = 63
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hsync_i,
  input  logic                vsync_i,
  input  logic                multi_freq_i,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic [1:0]          mode_o,
  output logic                mode4_o,
  output logic [PRESET_W-1:0] preset_o
);
  logic            tick;
  logic [N_CH-1:0] raw, fixed, pol_neg;
  mode_e           mode;

  assign raw[CH_H] = hsync_i;
  assign raw[CH_V] = vsync_i;

  spm_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    spm_pol_integ #(
      .CNT_MAX(CNT_MAX),
      .HI_TH  (HI_TH),
      .LO_TH  (LO_TH)
    ) i_integ (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .sync_i   (raw[c]),
      .pol_neg_o(pol_neg[c]),
      .sync_o   (fixed[c])
    );
  end

  spm_mode_dec i_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pol_neg_i   (pol_neg),
    .multi_freq_i(multi_freq_i),
    .mode_o      (mode),
    .mode4_o     (mode4_o),
    .preset_o    (preset_o)
  );

  assign hsync_o = fixed[CH_H];
  assign vsync_o = fixed[CH_V];
  assign mode_o  = mode;

  initial begin
    assert_params_R3: assert (LO_TH < HI_TH && HI_TH <= CNT_MAX && TICK_DIV >= 1);
  end
endmodule

// File: tb/test_sync_pol_mode.sv
module test_sync_pol_mode;
  localparam int DIV  = 4;
  localparam int CMAX = 63;
  localparam int HI   = 44;
  localparam int LO   = 19;
  localparam int T_UP = HI;
  localparam int T_DN = CMAX - LO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, ovr = 1'b0;
  logic hs_o, vs_o, m4_o;
  logic [1:0] mode_o;
  logic [10:0] preset_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_pol_mode #(.TICK_DIV(DIV), .CNT_MAX(CMAX), .HI_TH(HI), .LO_TH(LO)) i_sync_pol_mode (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs), .multi_freq_i(ovr),
    .hsync_o(hs_o), .vsync_o(vs_o), .mode_o(mode_o), .mode4_o(m4_o), .preset_o(preset_o)
  );

  function automatic int exp_mode(bit hn, bit vn);
    if (!hn && vn) return 0;
    if (hn && !vn) return 1;
    if (hn && vn)  return 2;
    return 3;
  endfunction

  function automatic int exp_preset(int m, bit o);
    if (o) return 1000;
    if (m == 0) return 1168;
    if (m == 1) return 1022;
    return 1000;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // random pulse trains, active width <= 30%, optional per-cycle output check
  task automatic run_trains(bit hn, bit vn, bit v_used, int cycles, bit chk);
    int hp = 20, hw = 4, hph = 0, vp = 80, vw = 10, vph = 0;
    int bad_h = 0, bad_v = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (chk) begin
        if (hs_o !== (hs ^ hn)) bad_h++;
        if (vs_o !== (vs ^ vn)) bad_v++;
      end
      hph++;
      if (hph >= hp) begin hph = 0; hp = 16 + $urandom_range(0, 24); hw = 1 + $urandom_range(0, hp * 3 / 10 - 1); end
      vph++;
      if (vph >= vp) begin vph = 0; vp = 60 + $urandom_range(0, 40); vw = 1 + $urandom_range(0, vp * 3 / 10 - 1); end
      hs = (hph < hw) ^ hn;
      vs = v_used ? ((vph < vw) ^ vn) : 1'b0;
    end
    if (chk) begin
      check(bad_h == 0, "R5 hsync_o", bad_h, 0);
      check(bad_v == 0, "R5 vsync_o", bad_v, 0);
    end
  endtask

  task automatic check_state(bit hn, bit vn, string tag);
    int m;
    m = exp_mode(hn, vn);
    check(mode_o == 2'(m), {"R6 mode ", tag}, mode_o, m);
    check(m4_o == (m == 3), {"R7 flag ", tag}, m4_o, m == 3);
    check(preset_o == 11'(exp_preset(m, ovr)), {"R8 preset ", tag}, preset_o, exp_preset(m, ovr));
  endtask

  task automatic measure_flip(logic lvl, string req);
    logic [1:0] m0;
    int k;
    m0 = mode_o;
    k = 0;
    hs = lvl;
    do begin @(negedge clk); k++; end while (mode_o == m0 && k < 1000);
    check(k >= (T_UP - 1) * DIV + 3 && k <= T_UP * DIV + 2, req, k, T_UP * DIV);
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit hn, vn;
    int bad;
    void'($urandom(32'h5A17));
    hold(3);
    // R1: reset values
    check(mode_o == 2'd3 && m4_o == 1'b1, "R1 mode/flag in reset", {mode_o, m4_o}, 7);
    check(preset_o == 11'd1000 && hs_o == 1'b0 && vs_o == 1'b0, "R1 preset/sync in reset", preset_o, 1000);
    rst_n = 1'b1;
    hold(2);
    check(mode_o == 2'd3 && m4_o == 1'b1 && preset_o == 11'd1000, "R1 after release", mode_o, 3);

    // R6/R7/R8/R5: all four polarity pairs
    for (int c = 0; c < 4; c++) begin
      hn = c[0]; vn = c[1];
      run_trains(hn, vn, 1'b1, 1500, 1'b0);
      run_trains(hn, vn, 1'b1, 400, 1'b1);
      check_state(hn, vn, "directed");
    end
    // random pairs with random override (R9)
    for (int r = 0; r < 6; r++) begin
      hn = $urandom_range(0, 1); vn = $urandom_range(0, 1);
      ovr = $urandom_range(0, 1);
      run_trains(hn, vn, 1'b1, 1500, 1'b0);
      run_trains(hn, vn, 1'b1, 300, 1'b1);
      check_state(hn, vn, ovr ? "random R9 ovr" : "random");
    end
    ovr = 1'b0;

    // R9: override on mode code 0
    run_trains(1'b0, 1'b1, 1'b1, 1500, 1'b0);
    check(preset_o == 11'd1168, "R8 boost before override", preset_o, 1168);
    @(negedge clk); ovr = 1'b1;
    @(negedge clk);
    check(preset_o == 11'd1000, "R9 override forces unity", preset_o, 1000);
    check(mode_o == 2'd0 && m4_o == 1'b0, "R9 mode kept under override", mode_o, 0);
    @(negedge clk); ovr = 1'b0;
    @(negedge clk);
    check(preset_o == 11'd1168, "R9 release restores preset", preset_o, 1168);

    // R10: fresh reset, vertical tied low
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0; hold(2); rst_n = 1'b1;
    run_trains(1'b1, 1'b0, 1'b0, 2000, 1'b0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (vs_o !== 1'b0) bad++;
    end
    check(bad == 0, "R10 vsync_o stays low", bad, 0);
    check(mode_o == 2'd1, "R10 mode from horizontal only", mode_o, 1);

    // R3: short reversal does not flip
    hs = 1'b0; hold(400);
    check(mode_o == 2'd3, "R3 settled positive", mode_o, 3);
    hs = 1'b1;
    bad = 0;
    for (int i = 0; i < (HI - 6) * DIV; i++) begin @(negedge clk); if (mode_o != 2'd3) bad++; end
    hs = 1'b0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (mode_o != 2'd3) bad++; end
    check(bad == 0, "R3 short reversal ignored", bad, 0);

    // R4: latency window rising, then falling after long high (R2 saturation)
    measure_flip(1'b1, "R4 flip to negative");
    check(mode_o == 2'd1, "R4 mode after flip", mode_o, 1);
    hold(1500);
    measure_flip(1'b0, "R2 R4 saturated flip back");
    check(mode_o == 2'd3, "R4 mode after flip back", mode_o, 3);
    check(T_DN == T_UP, "R4 window symmetric", T_DN, T_UP);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule